// File: doc/BRIEF.md
# Alternating-Clock Byte Deserializer

This block recovers bytes from a two-wire link in which the wires take turns: while one of them strobes low, the other one carries the data level. Once an upstream start detector has opened a frame and raises the enable, the block watches both synchronized line levels. A falling edge on line A takes the level of line B as the next bit. A falling edge on line B takes the level of line A. Eight such captures, four from each line and strictly alternating, make one byte. Bits are shifted in most significant first.

The block reports each finished byte with a one-cycle valid strobe. It also recognises the closing pattern of a frame and reports it with a one-cycle end pulse. Any edge that breaks the alternation raises a one-cycle frame error. After an end or an error the block goes silent and drops the partial byte. It stays silent until the enable has gone low again, which hands control back to start detection. Checking of frame length and checksum takes place further downstream.

Top module: `alt_byte_deser`

## Requirements
- R1: After a synchronous active-low reset, `byte_valid_o`, `end_pulse_o` and `frame_error_o` are 0 and `byte_o` is 0x00.
- R2: A falling edge of line A, seen while the A-capture count equals the B-capture count, shifts in the current level of line B as the next bit.
- R3: A falling edge of line B, seen while the A-capture count is one more than the B-capture count, shifts in the current level of line A as the next bit.
- R4: A byte is 8 captured bits, the first capture in bit 7. It is reported on `byte_o` with a single-cycle `byte_valid_o` only once line A is high after the fourth B capture. While A stays low, no byte is reported.
- R5: A falling edge of line B while line A is high and no bit of the byte has been captured is a lead-in and is ignored. This is allowed once per byte; a second one in the same byte is a frame error.
- R6: If the first capture of a byte is 0 and line A falls a second time with line B low, the block waits for the end of the frame. Both lines being high then gives a single-cycle `end_pulse_o`.
- R7: While waiting for the end of the frame, a falling edge on either line gives `frame_error_o` instead of an end pulse.
- R8: An edge that breaks the alternation gives a single-cycle `frame_error_o`. This includes two A captures in a row outside the end case, a B edge out of turn, and both lines falling in the same cycle.
- R9: After an end pulse or a frame error, the partial byte is discarded and no strobe of any kind appears until `frame_en_i` has been low. A new frame then starts from an empty byte.
- R10: While `frame_en_i` is low, no output strobe is raised. At most one of the three strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_en_i | input | 1 | High while the start detector holds a frame open |
| line_a_i | input | 1 | Synchronized level of line A |
| line_b_i | input | 1 | Synchronized level of line B |
| byte_o | output | BYTE_W | Last completed byte, MSB first capture in the top bit |
| byte_valid_o | output | 1 | One-cycle strobe: `byte_o` holds a new byte |
| end_pulse_o | output | 1 | One-cycle strobe: frame closed correctly |
| frame_error_o | output | 1 | One-cycle strobe: framing violation |

## Verification
Bit capture on line A and bit capture on line B can be triggered in the same sample when both lines drop together. That cycle must not be accepted as two bits. The bench provokes it by lowering both lines in one step from the idle high state. It judges the result at the ports: exactly one frame error, and no byte is reported. A second overlap is between a finished byte and the closing of the frame. The bench therefore sends a full series of table bytes followed directly by the end pattern, and requires every byte before the single end pulse, with nothing reported afterwards.

// File: rtl/alt_deser_pkg.sv
// Package: shared types of the alternating-clock byte deserializer.
// Assumes: nothing beyond IEEE 1800-2017.
package alt_deser_pkg;

    // Phase of the per-byte sequencer.
    typedef enum logic [1:0] {
        SEQ_BITS      = 2'd0,   // collecting alternating captures
        SEQ_WAIT_HIGH = 2'd1,   // all captures in, waiting for line A high
        SEQ_END_WAIT  = 2'd2    // closing pattern armed, waiting for both high
    } seq_state_t;

endpackage

// File: rtl/alt_edge_detect.sv
// Module: falling-edge detector for a bundle of already synchronized lines.
// Does:    flags, per line, a high-to-low change between consecutive samples.
// Assumes: inputs are synchronous to clk; flags are forced low while not armed.
module alt_edge_detect #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [LINES-1:0] lvl,
    output logic [LINES-1:0] fall
);

    logic [LINES-1:0] prev_q;

    // Keep the previous sample of every line.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    // One detector per line.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign fall[g] = arm & prev_q[g] & ~lvl[g];
    end

endmodule

// File: rtl/alt_bit_sequencer.sv
// Module: per-byte capture sequencer.
// Does:    enforces strict A/B alternation, shifts bits MSB first, handles the
//          lead-in edge, the byte completion wait and the closing pattern.
//          Raises single-cycle event flags (combinational) for the top level.
// Assumes: BYTE_W is even; fall flags come from the same samples as lvl_*.
module alt_bit_sequencer
    import alt_deser_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              lvl_a,
    input  logic              lvl_b,
    input  logic              fall_a,
    input  logic              fall_b,
    output logic [BYTE_W-1:0] data_o,
    output logic              byte_done_o,
    output logic              end_hit_o,
    output logic              err_hit_o
);

    localparam int HALF  = BYTE_W / 2;
    localparam int CNT_W = $clog2(HALF + 1);
    localparam logic [CNT_W-1:0] LAST_B = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    seq_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_a_q, cnt_a_d;
    logic [CNT_W-1:0]  cnt_b_q, cnt_b_d;
    logic              lead_q, lead_d;
    logic [BYTE_W-1:0] shift_q, shift_d;
    logic              done_c, end_c, err_c;

    // Next-state decision for one sample of both lines.
    always_comb begin
        state_d = state_q;
        cnt_a_d = cnt_a_q;
        cnt_b_d = cnt_b_q;
        lead_d  = lead_q;
        shift_d = shift_q;
        done_c  = 1'b0;
        end_c   = 1'b0;
        err_c   = 1'b0;

        unique case (state_q)
            SEQ_BITS: begin
                if (fall_a && fall_b) begin
                    err_c = 1'b1;
                end else if (fall_a) begin
                    if (cnt_a_q == cnt_b_q) begin
                        shift_d = {shift_q[BYTE_W-2:0], lvl_b};
                        cnt_a_d = cnt_a_q + ONE;
                    end else if (cnt_a_q == ONE && cnt_b_q == '0
                                 && !shift_q[0] && !lvl_b) begin
                        state_d = SEQ_END_WAIT;
                    end else begin
                        err_c = 1'b1;
                    end
                end else if (fall_b) begin
                    if (cnt_a_q == cnt_b_q + ONE) begin
                        shift_d = {shift_q[BYTE_W-2:0], lvl_a};
                        cnt_b_d = cnt_b_q + ONE;
                        if (cnt_b_q == LAST_B) state_d = SEQ_WAIT_HIGH;
                    end else if (cnt_a_q == '0 && cnt_b_q == '0
                                 && lvl_a && !lead_q) begin
                        lead_d = 1'b1;
                    end else begin
                        err_c = 1'b1;
                    end
                end
            end
            SEQ_WAIT_HIGH: begin
                if (lvl_a) done_c = 1'b1;
            end
            SEQ_END_WAIT: begin
                if (lvl_a && lvl_b)        end_c = 1'b1;
                else if (fall_a || fall_b) err_c = 1'b1;
            end
            default: err_c = 1'b1;
        endcase

        // Every event, or an inactive frame, starts a fresh byte.
        if (done_c || end_c || err_c || !active) begin
            state_d = SEQ_BITS;
            cnt_a_d = '0;
            cnt_b_d = '0;
            lead_d  = 1'b0;
            shift_d = (done_c && active) ? shift_q : '0;
        end
    end

    // Sequencer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_BITS;
            cnt_a_q <= '0;
            cnt_b_q <= '0;
            lead_q  <= 1'b0;
            shift_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_a_q <= cnt_a_d;
            cnt_b_q <= cnt_b_d;
            lead_q  <= lead_d;
            shift_q <= shift_d;
        end
    end

    assign data_o      = shift_q;
    assign byte_done_o = done_c & active;
    assign end_hit_o   = end_c & active;
    assign err_hit_o   = err_c & active;

endmodule

// File: rtl/alt_byte_deser.sv
// Module: alternating-clock byte deserializer, top level.
// Does:    detects line edges, runs the capture sequencer and registers the
//          byte, valid, end and error strobes; closes itself after an end
//          or an error until the enable has been dropped.
// Assumes: line inputs already synchronized; frame_en_i from a start detector.
module alt_byte_deser #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_en_i,
    input  logic              line_a_i,
    input  logic              line_b_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_valid_o,
    output logic              end_pulse_o,
    output logic              frame_error_o
);

    logic              closed_q;
    logic              active;
    logic [1:0]        fall;
    logic [BYTE_W-1:0] data;
    logic              byte_done, end_hit, err_hit;

    assign active = frame_en_i & ~closed_q;

    alt_edge_detect #(.LINES(2)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (active),
        .lvl  ({line_b_i, line_a_i}),
        .fall (fall)
    );

    alt_bit_sequencer #(.BYTE_W(BYTE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .lvl_a      (line_a_i),
        .lvl_b      (line_b_i),
        .fall_a     (fall[0]),
        .fall_b     (fall[1]),
        .data_o     (data),
        .byte_done_o(byte_done),
        .end_hit_o  (end_hit),
        .err_hit_o  (err_hit)
    );

    // Output strobes, byte holding register and frame-closed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_o        <= '0;
            byte_valid_o  <= 1'b0;
            end_pulse_o   <= 1'b0;
            frame_error_o <= 1'b0;
            closed_q      <= 1'b0;
        end else begin
            byte_valid_o  <= byte_done;
            end_pulse_o   <= end_hit;
            frame_error_o <= err_hit;
            if (byte_done) byte_o <= data;
            closed_q      <= frame_en_i & (closed_q | end_hit | err_hit);
        end
    end

endmodule

// File: rtl/alt_deser_checker.sv
// Module: property checker for alt_byte_deser, attached with bind.
// Does:    checks strobe exclusivity, strobe length and quiet periods.
// Assumes: observes top-level ports only.
module alt_deser_checker (
    input logic clk,
    input logic rst_n,
    input logic frame_en_i,
    input logic line_a_i,
    input logic byte_valid_o,
    input logic end_pulse_o,
    input logic frame_error_o
);

    // R10: never two strobes at once.
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({byte_valid_o, end_pulse_o, frame_error_o}));

    // R10: a disabled frame raises nothing in the following cycle.
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_en_i |=> !(byte_valid_o || end_pulse_o || frame_error_o));

    // R4: byte strobe lasts one cycle and follows a high line A.
    a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |=> !byte_valid_o);
    a_r4_after_a_high: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> $past(line_a_i));

    // R6: end pulse lasts one cycle.
    a_r6_end_single: assert property (@(posedge clk) disable iff (!rst_n)
        end_pulse_o |=> !end_pulse_o);

    // R9: after end or error the block is silent in the next cycle.
    a_r9_closed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (end_pulse_o || frame_error_o) |=>
            !(byte_valid_o || end_pulse_o || frame_error_o));

endmodule

bind alt_byte_deser alt_deser_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_en_i   (frame_en_i),
    .line_a_i     (line_a_i),
    .byte_valid_o (byte_valid_o),
    .end_pulse_o  (end_pulse_o),
    .frame_error_o(frame_error_o)
);

// File: tb/alt_byte_deser_tb.sv
module alt_byte_deser_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       la = 1'b1;
    logic       lb = 1'b1;
    logic [7:0] byte_o;
    logic       bv, endp, ferr;

    int checks = 0;
    int errors = 0;
    int nbytes = 0;
    int nend   = 0;
    int nerr   = 0;
    logic [7:0] got [64];
    bit finished = 1'b0;

    localparam int NVEC = 6;
    localparam logic [7:0] VEC [NVEC] = '{8'h3C, 8'hA5, 8'h00, 8'hFF, 8'h80, 8'h01};

    always #5 clk = ~clk;

    alt_byte_deser #(.BYTE_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_en_i(en),
        .line_a_i(la), .line_b_i(lb),
        .byte_o(byte_o), .byte_valid_o(bv),
        .end_pulse_o(endp), .frame_error_o(ferr)
    );

    // Monitor: record strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bv) begin
                if (nbytes < 64) got[nbytes] = byte_o;
                nbytes++;
            end
            if (endp) nend++;
            if (ferr) nerr++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic a, input logic b);
        @(negedge clk);
        la = a;
        lb = b;
        repeat (2) @(negedge clk);
    endtask

    // Eight captures; line A left at the last bit level.
    task automatic send_bits(input logic [7:0] d);
        for (int i = 0; i < 4; i++) begin
            step(1'b1, d[7-2*i]);
            step(1'b0, d[7-2*i]);
            step(1'b0, 1'b1);
            step(d[6-2*i], 1'b1);
            step(d[6-2*i], 1'b0);
        end
    endtask

    task automatic send_byte(input logic [7:0] d);
        send_bits(d);
        step(1'b1, 1'b0);
    endtask

    task automatic end_seq();
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b1, 1'b1);
    endtask

    task automatic reopen();
        @(negedge clk);
        en = 1'b0;
        la = 1'b1;
        lb = 1'b1;
        repeat (3) @(negedge clk);
        en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int b0, e0, r0;
        repeat (3) @(negedge clk);
        chk(bv == 0 && endp == 0 && ferr == 0 && byte_o == 8'h00,
            "R1 reset state", {bv, endp, ferr}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10: enable low, a full byte gives nothing.
        send_byte(8'h5A);
        chk(nbytes == 0 && nerr == 0, "R10 disabled quiet", nbytes, 0);

        // R4/R5: first byte starts with 0 from idle high B (lead-in).
        reopen();
        send_bits(VEC[0]);
        repeat (4) @(negedge clk);
        chk(nbytes == 0, "R4 no byte while A low", nbytes, 0);
        step(1'b1, 1'b0);
        chk(nbytes == 1, "R4 byte after A high", nbytes, 1);
        chk(nerr == 0, "R5 lead-in ignored", nerr, 0);

        // R2/R3/R4: table of bytes.
        for (int k = 1; k < NVEC; k++) send_byte(VEC[k]);
        for (int k = 0; k < NVEC; k++)
            chk(got[k] == VEC[k], "R2 R3 table byte", got[k], VEC[k]);

        // R6: closing pattern right after the bytes.
        end_seq();
        chk(nend == 1 && nerr == 0, "R6 end pulse", nend, 1);
        chk(nbytes == NVEC, "R6 bytes before end", nbytes, NVEC);

        // R9: closed until enable drops.
        send_byte(8'hC3);
        chk(nbytes == NVEC && nend == 1 && nerr == 0, "R9 quiet after end", nbytes, NVEC);

        // R5: second lead-in in one byte.
        reopen();
        r0 = nerr;
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        chk(nerr == r0 + 1, "R5 second lead-in error", nerr, r0 + 1);

        // R8: two A captures in a row with first bit 1.
        reopen();
        r0 = nerr;
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        chk(nerr == r0 + 1, "R8 double A edge", nerr, r0 + 1);

        // R8: both lines fall together.
        reopen();
        r0 = nerr;
        b0 = nbytes;
        step(1'b0, 1'b0);
        chk(nerr == r0 + 1 && nbytes == b0, "R8 simultaneous fall", nerr, r0 + 1);

        // R7: falling edge while waiting for the end.
        reopen();
        r0 = nerr;
        e0 = nend;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        chk(nerr == r0 + 1 && nend == e0, "R7 edge in end wait", nerr, r0 + 1);

        // R9: partial byte discarded after an error.
        reopen();
        b0 = nbytes;
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        reopen();
        send_byte(8'h69);
        chk(nbytes == b0 + 1 && got[b0] == 8'h69, "R9 fresh byte after error",
            got[b0], 8'h69);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule